// File: doc/BRIEF.md
# Two-Write Coefficient Memory Loader

This block fills a coefficient memory for a filter datapath from a 16-bit control bus. Each 20-bit coefficient arrives as a pair of bus writes to one register address. The first write of the pair carries the high sixteen bits and the second carries the low four. When the pair is complete, the joined word is stored at the next location of a write pointer. The pointer counts up from location zero, which holds the outermost tap. For a symmetric filter only half the taps are loaded, and the last word written is the centre tap.

The pointer and the half-word toggle go back to their start in two ways. An asynchronous global reset does this and leaves the stored words untouched. A filter-disable level does it on its rising edge and also pauses the filter, so that software can reload the coefficients without touching other settings. The filter runs again when the disable level falls or when a start pulse arrives. The filter datapath reads the memory through a registered read port.

Top module: `coef_loader_top`

## Requirements
- R1: After reset, `load_count` is 0, `lo_pending` is 0 (the next write is an upper half) and `run` is 1.
- R2: The stored coefficient is {first write bits 15:0, second write bits 3:0}. Bit 19 is the MSB, and bits 15:4 of the second write are ignored.
- R3: Completed pairs are stored at consecutive locations starting at 0, and `load_count` rises by one for each stored word.
- R4: The first write of a pair raises `lo_pending` and leaves `load_count` and the memory unchanged. The memory is written only when the second write arrives.
- R5: Reset clears the pointer and the toggle and keeps every stored coefficient.
- R6: On the first cycle `fir_dis` is seen high, the pointer and the toggle go to zero and `run` goes to 0. Stored words stay until they are overwritten.
- R7: `run` returns to 1 on the first cycle `fir_dis` is seen low after being high, or on any cycle with `start_in` high.
- R8: The pointer stops at DEPTH (16 by default). Pairs completed after that change neither the memory nor `load_count`.
- R9: A bus write in the same cycle as the `fir_dis` rising edge is discarded.
- R10: `rd_coef` presents the word at `rd_addr` one clock after the address is applied.
- R11: When the `fir_dis` rising edge and `start_in` fall in the same cycle, `run` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| cbus_wr | input | 1 | Write strobe for the coefficient register |
| cbus_data | input | 16 | Control bus write data |
| fir_dis | input | 1 | Filter-disable level |
| start_in | input | 1 | Start pulse that resumes the filter |
| rd_addr | input | ADDR_W (4) | Read address from the filter datapath |
| rd_coef | output | 20 | Registered coefficient read data |
| load_count | output | CNT_W (5) | Write pointer, equal to the number of words stored |
| lo_pending | output | 1 | 1 when the next write is expected to be a lower half |
| run | output | 1 | Filter running |

## Verification
The rewind and the bus write can fall in the same cycle. This happens when the lower half of a pair arrives on the clock where `fir_dis` first reads high. The bench provokes it by raising the disable level and driving the completing write on the same clock. It then judges the result at the ports: `load_count` and `lo_pending` must both be zero, and a scoreboarded read of the slot the pair would have filled must return its old word. A second collision puts `start_in` on the same disable edge, and `run` must come out low.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int BUS_W  = 16;
  localparam int COEF_W = 20;
  localparam int LO_W   = COEF_W - BUS_W;

  // Joins an upper bus half and the low nibble of a second write.
  function automatic logic [COEF_W-1:0] coef_join(input logic [BUS_W-1:0] hi,
                                                  input logic [BUS_W-1:0] lo);
    logic [COEF_W-1:0] w;
    w = {hi, lo[LO_W-1:0]};
    return w;
  endfunction
endpackage

// File: rtl/coef_pair_asm.sv
module coef_pair_asm
  import coef_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rewind,
  input  logic [BUS_W-1:0]  data,
  output logic              lo_pend,
  output logic              word_valid,
  output logic [COEF_W-1:0] word
);
  logic [BUS_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_pend <= 1'b0;
      hi_q    <= '0;
    end else if (rewind) begin
      lo_pend <= 1'b0;
    end else if (accept) begin
      if (!lo_pend) hi_q <= data;
      lo_pend <= ~lo_pend;
    end
  end

  assign word_valid = accept & lo_pend;
  assign word       = coef_join(hi_q, data);

  AST_REWIND_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> !lo_pend); // R6
endmodule

// File: rtl/coef_wr_ptr.sv
module coef_wr_ptr #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rewind,
  input  logic             word_valid,
  output logic [CNT_W-1:0] ptr,
  output logic             full,
  output logic             mem_we
);
  assign full   = (ptr == CNT_W'(DEPTH));
  assign mem_we = word_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (rewind) ptr <= '0;
    else if (mem_we) ptr <= ptr + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= CNT_W'(DEPTH)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rewind) |=> full); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !full && !rewind) |=> (ptr == $past(ptr) + 1'b1)); // R3
  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (ptr == '0)); // R6
endmodule

// File: rtl/coef_run_ctrl.sv
module coef_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic fir_dis,
  input  logic start_in,
  output logic rewind,
  output logic run
);
  logic dis_q;
  logic dis_fall;

  assign rewind   = fir_dis & ~dis_q;
  assign dis_fall = ~fir_dis & dis_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= 1'b0;
      run   <= 1'b1;
    end else begin
      dis_q <= fir_dis;
      if (rewind)                   run <= 1'b0;
      else if (dis_fall | start_in) run <= 1'b1;
    end
  end

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && start_in) |=> !run); // R11
  AST_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (start_in && !rewind) |=> run); // R7
endmodule

// File: rtl/coef_store.sv
module coef_store
  import coef_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [COEF_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [COEF_W-1:0] rd
);
  logic [COEF_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we && (wa == ADDR_W'(g))) mem[g] <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd <= '0;
    else        rd <= mem[ra];
  end
endmodule

// File: rtl/coef_loader_top.sv
module coef_loader_top
  import coef_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cbus_wr,
  input  logic [BUS_W-1:0]  cbus_data,
  input  logic              fir_dis,
  input  logic              start_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [COEF_W-1:0] rd_coef,
  output logic [CNT_W-1:0]  load_count,
  output logic              lo_pending,
  output logic              run
);
  logic              rewind;
  logic              accept;
  logic              word_valid;
  logic [COEF_W-1:0] word;
  logic              full;
  logic              mem_we;

  assign accept = cbus_wr & ~rewind;

  coef_run_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fir_dis(fir_dis), .start_in(start_in),
    .rewind(rewind), .run(run)
  );

  coef_pair_asm u_asm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rewind(rewind),
    .data(cbus_data), .lo_pend(lo_pending), .word_valid(word_valid), .word(word)
  );

  coef_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .rewind(rewind), .word_valid(word_valid),
    .ptr(load_count), .full(full), .mem_we(mem_we)
  );

  coef_store #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wa(load_count[ADDR_W-1:0]),
    .wd(word), .ra(rd_addr), .rd(rd_coef)
  );

  AST_UPPER_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (cbus_wr && !lo_pending && !rewind) |=> (lo_pending && $stable(load_count))); // R4
  AST_CLASH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cbus_wr && rewind) |=> (load_count == '0 && !lo_pending)); // R9
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rewind) |-> !mem_we); // R8
endmodule

// File: tb/sim_coef_loader_top.sv
`timescale 1ns/1ps
module sim_coef_loader_top;
  localparam int DEPTH = 16;
  localparam time TCK = 8ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cbus_wr = 1'b0;
  logic [15:0] cbus_data = '0;
  logic        fir_dis = 1'b0;
  logic        start_in = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [19:0] rd_coef;
  logic [4:0]  load_count;
  logic        lo_pending;
  logic        run;

  always #(TCK/2) clk = ~clk;

  coef_loader_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cbus_wr(cbus_wr), .cbus_data(cbus_data),
    .fir_dis(fir_dis), .start_in(start_in), .rd_addr(rd_addr),
    .rd_coef(rd_coef), .load_count(load_count), .lo_pending(lo_pending), .run(run)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int unsigned model_mem [DEPTH];
  int          model_cnt = 0;

  logic [19:0] exp_q[$];
  string       tag_q[$];
  logic        rd_v = 1'b0;
  logic        rd_pend = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares one registered read per flagged cycle.
  always @(posedge clk) rd_pend <= rd_v;
  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [19:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(rd_coef), int'(e));
    end
  end

  task automatic rd_push(input int a, input string req);
    rd_addr = 4'(a);
    rd_v = 1'b1;
    exp_q.push_back(20'(model_mem[a]));
    tag_q.push_back(req);
    @(negedge clk);
    rd_v = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] d);
    cbus_wr = 1'b1;
    cbus_data = d;
    @(negedge clk);
    cbus_wr = 1'b0;
  endtask

  task automatic write_pair(input logic [15:0] hi, input logic [15:0] lo);
    bus_write(hi);
    bus_write(lo);
    if (model_cnt < DEPTH) begin
      model_mem[model_cnt] = (int'(hi) << 4) | (int'(lo) & 'hF);
      model_cnt++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_cnt = 0;
  endtask

  initial begin
    #(TCK * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(load_count), 0);
    chk("R1 lo_pending", int'(lo_pending), 0);
    chk("R1 run", int'(run), 1);

    bus_write(16'h8A5C);
    chk("R4 count after upper", int'(load_count), 0);
    chk("R4 lo_pending after upper", int'(lo_pending), 1);
    bus_write(16'hABC7);
    model_mem[0] = ('h8A5C << 4) | 'h7;
    model_cnt = 1;
    chk("R3 count after pair", int'(load_count), 1);
    chk("R4 lo_pending after pair", int'(lo_pending), 0);

    for (int i = 1; i < 6; i++)
      write_pair(16'(i * 16'h1111 + 16'h0F01), 16'(16'hFFF0 | i));
    chk("R3 count six", int'(load_count), 6);
    for (int i = 0; i < 6; i++) rd_push(i, "R2 R10 stored word");
    flush();

    for (int i = 6; i < DEPTH; i++) write_pair(16'(16'h7000 + i), 16'(i));
    chk("R8 count full", int'(load_count), DEPTH);
    write_pair(16'h1234, 16'h0005);
    chk("R8 count after extra pair", int'(load_count), DEPTH);
    rd_push(DEPTH - 1, "R8 last word unchanged");
    rd_push(0, "R8 first word unchanged");
    flush();

    bus_write(16'h4444);
    do_reset();
    chk("R5 count after reset", int'(load_count), 0);
    chk("R5 lo_pending after reset", int'(lo_pending), 0);
    for (int i = 0; i < 4; i++) rd_push(i, "R5 word kept over reset");
    flush();

    write_pair(16'hC001, 16'h0001);
    write_pair(16'hC002, 16'h0002);
    write_pair(16'hC003, 16'h0003);
    bus_write(16'hDEAD);
    chk("R4 pending before disable", int'(lo_pending), 1);
    fir_dis = 1'b1;
    @(negedge clk);
    model_cnt = 0;
    chk("R6 count after disable", int'(load_count), 0);
    chk("R6 lo_pending after disable", int'(lo_pending), 0);
    chk("R6 run after disable", int'(run), 0);
    rd_push(2, "R6 word kept over disable");
    write_pair(16'hE100, 16'h000A);
    write_pair(16'hE200, 16'h000B);
    chk("R6 count while disabled", int'(load_count), 2);
    rd_push(0, "R6 reload slot 0");
    rd_push(1, "R6 reload slot 1");
    rd_push(2, "R6 slot 2 untouched");
    flush();

    fir_dis = 1'b0;
    @(negedge clk);
    chk("R7 run after enable", int'(run), 1);
    fir_dis = 1'b1;
    @(negedge clk);
    model_cnt = 0;
    chk("R7 run low before start", int'(run), 0);
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    chk("R7 run after start", int'(run), 1);

    fir_dis = 1'b0;
    @(negedge clk);
    write_pair(16'hF0F0, 16'h0009);
    bus_write(16'h3333);
    fir_dis = 1'b1;
    cbus_wr = 1'b1;
    cbus_data = 16'h000E;
    @(negedge clk);
    cbus_wr = 1'b0;
    model_cnt = 0;
    chk("R9 count after clash", int'(load_count), 0);
    chk("R9 lo_pending after clash", int'(lo_pending), 0);
    rd_push(1, "R9 slot 1 not written");
    flush();

    fir_dis = 1'b0;
    @(negedge clk);
    fir_dis = 1'b1;
    start_in = 1'b1;
    @(negedge clk);
    start_in = 1'b0;
    chk("R11 run on clash", int'(run), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule